// File: doc/BRIEF.md
# Serial Peripheral Master with Delayed Input Capture

This block is a single-channel master for a four-wire serial peripheral bus in clock mode 0. A one-cycle `start` request moves a parallel word out on `mosi`, most significant bit first. At the same time a word is gathered from `miso` and returned in parallel with a one-cycle `done` pulse. The serial clock half-period is a run-time count of system cycles. Chip select is active low and frames every transfer.

On some boards the input pins reach the fabric several system cycles after the output pins are driven. A loop through output buffer, wire, slave and input synchronizer then returns each bit late. If the master samples on the serial clock rising edge it reads the bit before the wanted one, and the received word comes back shifted right by one place. This block can postpone each sample by a programmable number of system cycles. The setting moves only the sample point. The lengths of the bit period and of the transfer never change, so the transfer stays deterministic.

Legal settings need `halfCycles` of at least 1 and `sampleDelay` smaller than `halfCycles`. This places each sample before the next rising edge.

Top module: `spi_delayed_master`

## Requirements
- R1: During and after synchronous reset, and whenever no transfer runs, `csN` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: On the clock edge that accepts `start`, `csN` goes low and `busy` goes high. The first `sclk` rising edge follows H cycles later, with H the latched `halfCycles`. `sclk` then alternates every H cycles and gives exactly WORD_W rising edges.
- R3: `mosi` carries the transmit word MSB first. Its first bit is driven on the edge where `csN` falls, and after that it changes only on `sclk` falling edges.
- R4: Bit k of the transfer (k = 0 for the MSB) is taken from `miso` on the system clock edge D cycles after the k-th `sclk` rising edge, with D the latched `sampleDelay`. For D = 0 that is the rising edge itself. The first captured bit becomes the MSB of `rxWord`.
- R5: `done` goes high for exactly one cycle, 2·WORD_W·H + H cycles after the accepting edge, whatever D is.
- R6: `csN` returns high on the same edge that raises `done`, H cycles after the last `sclk` falling edge.
- R7: `rxWord` takes the new received word on the edge that raises `done`, and holds it until the next `done`.
- R8: A `start` request while `busy` is 1 is ignored. It neither restarts nor lengthens the running transfer, and no second transfer follows.
- R9: `txWord`, `halfCycles` and `sampleDelay` are read only on the accepting edge. Changing them later has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Transfer request, one cycle |
| txWord | input | WORD_W | Word to transmit |
| halfCycles | input | HALF_W | Serial clock half-period in system cycles |
| sampleDelay | input | DLY_W | Cycles from serial clock rising edge to input capture |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rxWord | output | WORD_W | Last received word |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |

## Verification
The hard case is a returning bit that arrives in a different serial clock period from the one it belongs to. From the ports this happens only when pin latency and capture offset disagree. The bench therefore puts a slave model behind a delay line of selectable length on `miso`. It sweeps half-period, capture offset and latency together. For every combination it works out from the timing which slave bit lies under each capture edge, so transfers that come back shifted left, shifted right or correct are all predicted. A second `start` with changed word and settings is fired partway through one transfer to show that the running transfer is left untouched.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL
  } ctrlState_e;

  // One-cycle commands from control to datapath
  typedef struct packed {
    logic load;     // accept transfer: drop select, present first bit
    logic rise;     // serial clock goes high
    logic fall;     // serial clock goes low
    logic shift;    // present next transmit bit
    logic capture;  // take the input bit
    logic finish;   // release select, publish word, pulse done
  } ctrlStrobes_t;

endpackage

// File: rtl/spi_dly_ctrl.sv
module spi_dly_ctrl
  import spi_dly_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int HALF_W = 8,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [HALF_W-1:0] halfCycles,
  input  logic [DLY_W-1:0]  sampleDelay,
  output ctrlStrobes_t      stb,
  output logic              busy
);

  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int CMP_W = HALF_W + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  ctrlState_e        state, stateNext;
  logic [HALF_W-1:0] phaseCnt, cntNext;
  logic [HALF_W-1:0] halfReg;
  logic [DLY_W-1:0]  dlyReg;
  logic [BIT_W-1:0]  bitCnt, bitNext;

  logic              phaseEnd;
  logic              lastBit;
  logic              delayZero;
  logic [CMP_W-1:0]  cntPlus;
  logic [CMP_W-1:0]  dlyExt;

  assign phaseEnd  = (phaseCnt == halfReg - 1'b1);
  assign lastBit   = (bitCnt == LAST_BIT);
  assign delayZero = (dlyReg == '0);
  assign cntPlus   = {1'b0, phaseCnt} + 1'b1;
  assign dlyExt    = CMP_W'(dlyReg);

  always_comb begin
    stb       = '0;
    stateNext = state;
    cntNext   = phaseCnt + 1'b1;
    bitNext   = bitCnt;
    case (state)
      ST_IDLE: begin
        cntNext = '0;
        bitNext = '0;
        if (start) begin
          stb.load  = 1'b1;
          stateNext = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (phaseEnd) begin
          stb.rise    = 1'b1;
          stb.capture = delayZero;
          stateNext   = ST_HIGH;
          cntNext     = '0;
        end
      end
      ST_HIGH: begin
        if (!delayZero && cntPlus == dlyExt) stb.capture = 1'b1;
        if (phaseEnd) begin
          stb.fall = 1'b1;
          cntNext  = '0;
          if (lastBit) begin
            stateNext = ST_TRAIL;
          end else begin
            stb.shift = 1'b1;
            bitNext   = bitCnt + 1'b1;
            stateNext = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (phaseEnd) begin
          stb.rise    = 1'b1;
          stb.capture = delayZero;
          stateNext   = ST_HIGH;
          cntNext     = '0;
        end
      end
      ST_TRAIL: begin
        if (phaseEnd) begin
          stb.finish = 1'b1;
          stateNext  = ST_IDLE;
          cntNext    = '0;
          bitNext    = '0;
        end
      end
      default: begin
        stateNext = ST_IDLE;
        cntNext   = '0;
        bitNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      halfReg  <= '0;
      dlyReg   <= '0;
    end else begin
      state    <= stateNext;
      phaseCnt <= cntNext;
      bitCnt   <= bitNext;
      if (stb.load) begin
        halfReg <= halfCycles;
        dlyReg  <= sampleDelay;
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spi_dly_datapath.sv
module spi_dly_datapath
  import spi_dly_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      stb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              csN,
  output logic              sclk,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord,
  output logic              done
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      mosi    <= 1'b0;
    end else if (stb.load) begin
      txShift <= txWord;
      mosi    <= txWord[WORD_W-1];
    end else if (stb.shift) begin
      txShift <= {txShift[WORD_W-2:0], 1'b0};
      mosi    <= txShift[WORD_W-2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift <= '0;
    end else if (stb.capture) begin
      rxShift <= {rxShift[WORD_W-2:0], miso};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csN    <= 1'b1;
      sclk   <= 1'b0;
      rxWord <= '0;
      done   <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.load)   csN  <= 1'b0;
      if (stb.rise)   sclk <= 1'b1;
      if (stb.fall)   sclk <= 1'b0;
      if (stb.finish) begin
        csN    <= 1'b1;
        rxWord <= rxShift;
      end
    end
  end

endmodule

// File: rtl/spi_delayed_master.sv
module spi_delayed_master
  import spi_dly_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int HALF_W = 8,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] txWord,
  input  logic [HALF_W-1:0] halfCycles,
  input  logic [DLY_W-1:0]  sampleDelay,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rxWord,
  output logic              csN,
  output logic              sclk,
  output logic              mosi
);

  ctrlStrobes_t stb;

  spi_dly_ctrl #(
    .WORD_W(WORD_W),
    .HALF_W(HALF_W),
    .DLY_W (DLY_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .halfCycles (halfCycles),
    .sampleDelay(sampleDelay),
    .stb        (stb),
    .busy       (busy)
  );

  spi_dly_datapath #(
    .WORD_W(WORD_W)
  ) u_data (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .txWord(txWord),
    .miso  (miso),
    .csN   (csN),
    .sclk  (sclk),
    .mosi  (mosi),
    .rxWord(rxWord),
    .done  (done)
  );

endmodule

// File: rtl/spi_dly_checker.sv
module spi_dly_checker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] rxWord,
  input logic              csN,
  input logic              sclk,
  input logic              mosi
);

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (csN && !sclk));

  // R2
  sclk_framed_chk: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !csN);

  // R2
  select_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(csN) |-> $rose(busy));

  // R3
  mosi_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!csN && !$stable(mosi)) |-> ($fell(sclk) || $fell(csN)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  select_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (csN && !sclk));

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rxWord));

endmodule

bind spi_delayed_master spi_dly_checker #(.WORD_W(WORD_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .busy  (busy),
  .done  (done),
  .rxWord(rxWord),
  .csN   (csN),
  .sclk  (sclk),
  .mosi  (mosi)
);

// File: tb/spi_delayed_master_test.sv
module spi_delayed_master_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] txWord = '0;
  logic [7:0] halfCycles = 8'd1;
  logic [3:0] sampleDelay = '0;
  logic       miso;
  logic       busy, done, csN, sclk, mosi;
  logic [7:0] rxWord;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_delayed_master uut (
    .clk(clk), .rst(rst), .start(start), .txWord(txWord),
    .halfCycles(halfCycles), .sampleDelay(sampleDelay), .miso(miso),
    .busy(busy), .done(done), .rxWord(rxWord), .csN(csN),
    .sclk(sclk), .mosi(mosi)
  );

  // Slave model plus pin latency line, all moving on the falling clock
  logic [7:0]  slaveWord = '0;
  int          latency = 0;
  int          fallCnt = 0;
  logic        slaveCs = 1'b1;
  logic        sclkPrev = 1'b0;
  logic [7:0]  mosiGot = '0;
  logic [15:0] pipe = '0;
  logic        rawMiso;

  assign rawMiso = slaveCs ? 1'b0 : ((fallCnt < 8) ? slaveWord[7 - fallCnt] : 1'b0);
  assign miso    = (latency == 0) ? rawMiso : pipe[latency - 1];

  always @(negedge clk) begin
    slaveCs  <= csN;
    sclkPrev <= sclk;
    pipe     <= {pipe[14:0], rawMiso};
    if (csN) fallCnt <= 0;
    else if (sclkPrev && !sclk) fallCnt <= fallCnt + 1;
    if (!csN && !sclkPrev && sclk) mosiGot <= {mosiGot[6:0], mosi};
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Which slave bit sits under each capture edge, from the timing alone
  function automatic logic [7:0] expRx(input logic [7:0] sw, input int h, input int d, input int l);
    logic [7:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int rel = h + 2 * k * h + d - l;
      if (rel > 0) begin
        int c = (rel - 1) / (2 * h);
        if (c < 8) r[7 - k] = sw[7 - c];
      end
    end
    return r;
  endfunction

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sw,
                      input int h, input int d, input int l, input bit poke);
    int m = 0, rises = 0, firstRise = -1, doneAt = -1;
    logic prevS = 1'b0;
    logic [7:0] exp = expRx(sw, h, d, l);
    @(negedge clk);
    txWord = tx; slaveWord = sw; halfCycles = 8'(h); sampleDelay = 4'(d); latency = l;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: select low and busy on the accepting edge
    check(!csN && busy, "R2 select", {csN, busy}, 2'b01);
    while (doneAt < 0 && m < 2000) begin
      if (sclk && !prevS) begin
        rises++;
        if (firstRise < 0) firstRise = m;
      end
      prevS = sclk;
      if (done) doneAt = m;
      else begin
        if (poke && m == 3) begin
          start = 1'b1; txWord = ~tx; halfCycles = 8'(h + 3); sampleDelay = 4'(h + 1);
        end else start = 1'b0;
        @(negedge clk);
        m++;
      end
    end
    start = 1'b0;
    // R5: fixed transfer length
    check(doneAt == 17 * h, "R5 length", doneAt, 17 * h);
    // R2: first rising edge and count of edges
    check(firstRise == h && rises == 8, "R2 sclk", firstRise * 256 + rises, h * 256 + 8);
    // R6: select released with done
    check(csN == 1'b1, "R6 release", csN, 1);
    // R3: transmitted bits in order
    check(mosiGot == tx, "R3 mosi", mosiGot, tx);
    // R4, R7: received word against the timing model
    check(rxWord == exp, poke ? "R8 R9 rx" : "R4 rx", rxWord, exp);
    if (d <= l && d >= l - h + 1)
      check(rxWord == sw, "R4 aligned", rxWord, sw);
    @(negedge clk);
    // R5: one cycle pulse; R7: word held
    check(!done && rxWord == exp, "R7 hold", {done, rxWord}, {1'b0, exp});
    if (poke) begin
      repeat (5) @(negedge clk);
      // R8: no second transfer
      check(!busy && csN, "R8 no restart", {busy, csN}, 2'b01);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int run = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(csN && !sclk && !busy && !done, "R1 reset", {csN, sclk, busy, done}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    check(csN && !sclk && !busy && !done && rxWord == 0, "R1 idle", {csN, sclk, busy, done}, 4'b1000);
    for (int h = 1; h <= 4; h++)
      for (int d = 0; d < h; d++)
        for (int l = 0; l <= 5; l++) begin
          xfer(8'hA5 ^ 8'(run * 37), 8'h3C + 8'(run * 29), h, d, l, 1'b0);
          run++;
        end
    xfer(8'h81, 8'hC6, 16, 15, 15, 1'b0);
    xfer(8'h7E, 8'h59, 16, 15, 14, 1'b0);
    xfer(8'h12, 8'hB4, 16, 0, 15, 1'b0);
    xfer(8'hD3, 8'h2B, 3, 1, 2, 1'b1);
    xfer(8'h4C, 8'h96, 2, 0, 4, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule